// File: doc/BRIEF.md
# Sensor Register SPI Access Engine

This block is an SPI master that performs one register access at a time on an optical motion sensor. A requester offers a 7-bit register address, a write flag and a write byte over a ready/valid handshake. For each accepted request the engine pulls chip select low and clocks out a command byte in SPI mode 3. The command byte has the direction in its top bit and the address below it. For a write, one data byte follows. For a read, one byte is clocked in from the sensor, placed on `rdata` and flagged by a one-cycle `done` pulse.

After chip select is released the engine stays busy for a minimum idle time before it takes the next request. That time is longer after a write than after a read. It is counted in microseconds from a tick derived from the `CLK_FREQ` parameter. A request offered during that time waits on `req_ready` and is accepted as soon as the gap ends.

The controller has five states. IDLE (ready, lines parked) moves to LEAD when a request is accepted. LEAD (chip select low, clock still high, first bit on the data line) lasts one half period and then moves to LOW. LOW (clock low) moves to HIGH after one half period, with the input sampled on that rising edge. HIGH moves back to LOW after one half period, shifting the next output bit. After the last bit, HIGH moves to GAP instead and releases chip select. GAP (busy, lines parked) moves to IDLE when the idle time has run out.

Top module: `sensor_reg_spi`

## Requirements
- R1: Mode 3 framing: `spi_sclk` is high whenever `spi_cs_n` is high, and while `spi_cs_n` is low `spi_mosi` changes only while `spi_sclk` is low. The sensor's data is taken on each rising edge of `spi_sclk`.
- R2: A write request shifts out 16 bits. First comes the command byte {1, addr[6:0]}, then `req_wdata`, each most significant bit first.
- R3: A read request shifts out the command byte {0, addr[6:0]}, most significant bit first, followed by eight zero bits on `spi_mosi`.
- R4: `spi_cs_n` falls on the clock edge that accepts a request. It stays low for exactly 33 half periods: one lead half period plus 16 clock periods, where a half period is CLK_FREQ/(2*SCLK_FREQ) cycles. It rises right after the 16th rising edge of `spi_sclk` plus one half period.
- R5: After a read, the eight bits sampled on rising edges 9 to 16 (first sampled bit most significant) appear on `rdata`, and `done` is high for exactly one cycle, the first cycle with `spi_cs_n` high again. A write gives no `done` pulse and leaves `rdata` unchanged.
- R6: After a write frame, `busy` stays high and `req_ready` low for exactly WR_GAP_US × (CLK_FREQ/1 000 000) cycles after `spi_cs_n` rises, with `spi_cs_n` held high throughout.
- R7: After a read frame, the same holds with RD_GAP_US in place of WR_GAP_US.
- R8: `req_ready` equals not `busy`. A request held valid while busy is not lost: it is accepted on the first cycle `req_ready` is high, and its frame starts on that edge.
- R9: Out of reset: `spi_cs_n`=1, `spi_sclk`=1, `spi_mosi`=0, `busy`=0, `req_ready`=1, `done`=0, `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 7 | Sensor register address |
| req_wdata | input | 8 | Byte to write |
| rdata | output | 8 | Byte returned by the last read |
| done | output | 1 | One-cycle pulse when a read byte is on rdata |
| busy | output | 1 | Frame or idle gap in progress |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the sensor |
| spi_miso | input | 1 | Serial data from the sensor |

## Verification
The bound checker watches the cycle-level rules on every clock. It confirms that the clock is parked high whenever chip select is released and that the output bit never moves during a high clock phase. It checks that accepting a request drops chip select on the next cycle and that a released chip select always opens a busy gap. It also checks that `done` arrives only as a single pulse on the cycle chip select rises. Only the bench's scenarios can show the content of each frame, the byte returned from the modelled sensor, the exact frame and gap lengths that differ between reads and writes, and that a request held through a gap is served rather than lost.

// File: rtl/sensor_spi_pkg.sv
package sensor_spi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } spi_state_e;

    // Width of a counter that must hold values 0 .. n-1
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sensor_spi_halfcnt.sv
module sensor_spi_halfcnt #(
    parameter int HALF_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    import sensor_spi_pkg::*;

    localparam int HALF_EFF = (HALF_CYC < 1) ? 1 : HALF_CYC;
    localparam int HW       = cnt_width(HALF_EFF);
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_EFF - 1);

    logic [HW-1:0] cnt_q;

    assign expire = run && (cnt_q == HALF_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + HW'(1);
        end
    end

endmodule

// File: rtl/sensor_spi_gap_timer.sv
module sensor_spi_gap_timer #(
    parameter int TICK_CYC = 100,
    parameter int LONG_US  = 120,
    parameter int SHORT_US = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic long_sel,
    output logic expire
);
    import sensor_spi_pkg::*;

    localparam int TICK_EFF  = (TICK_CYC < 1) ? 1 : TICK_CYC;
    localparam int LONG_EFF  = (LONG_US  < 1) ? 1 : LONG_US;
    localparam int SHORT_EFF = (SHORT_US < 1) ? 1 : SHORT_US;
    localparam int MAX_US    = (LONG_EFF > SHORT_EFF) ? LONG_EFF : SHORT_EFF;
    localparam int TW        = cnt_width(TICK_EFF);
    localparam int UW        = cnt_width(MAX_US);

    logic [TW-1:0] tick_q;
    logic [UW-1:0] us_q;
    logic          tick;
    logic [UW-1:0] us_last;

    assign tick    = (tick_q == TW'(TICK_EFF - 1));
    assign us_last = long_sel ? UW'(LONG_EFF - 1) : UW'(SHORT_EFF - 1);
    assign expire  = run && tick && (us_q == us_last);

    // The prescaler restarts on every gap, so a gap is an exact multiple of TICK_CYC
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            us_q   <= '0;
        end else if (!run) begin
            tick_q <= '0;
            us_q   <= '0;
        end else begin
            tick_q <= tick ? '0 : tick_q + TW'(1);
            if (tick) begin
                us_q <= us_q + UW'(1);
            end
        end
    end

endmodule

// File: rtl/sensor_spi_shifter.sv
module sensor_spi_shifter #(
    parameter int FRAME_W = 16,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [FRAME_W-1:0] load_val,
    input  logic              shift_out,
    input  logic              sample_in,
    input  logic              miso,
    output logic              mosi_bit,
    output logic [DATA_W-1:0] rx_byte
);

    logic [FRAME_W-1:0] tx_q;
    logic [DATA_W-1:0]  rx_q;

    assign mosi_bit = tx_q[FRAME_W-1];
    assign rx_byte  = rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_val;
        end else if (shift_out) begin
            tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        end
    end

    // Every sampled bit enters; after the frame the last DATA_W remain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (sample_in) begin
            rx_q <= {rx_q[DATA_W-2:0], miso};
        end
    end

endmodule

// File: rtl/sensor_reg_spi.sv
module sensor_reg_spi #(
    parameter int CLK_FREQ  = 100_000_000,
    parameter int SCLK_FREQ = 2_000_000,
    parameter int WR_GAP_US = 120,
    parameter int RD_GAP_US = 20,
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              busy,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    import sensor_spi_pkg::*;

    localparam int CMD_W    = ADDR_W + 1;
    localparam int FRAME_W  = CMD_W + DATA_W;
    localparam int HALF_CYC = CLK_FREQ / (2 * SCLK_FREQ);
    localparam int TICK_CYC = CLK_FREQ / 1_000_000;
    localparam int BIT_W    = cnt_width(FRAME_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

    spi_state_e         state_q, state_d;
    logic [BIT_W-1:0]   bit_q;
    logic               is_read_q;
    logic               accept;
    logic               half_run, half_exp;
    logic               gap_exp;
    logic               last_bit;
    logic               frame_end;
    logic               shift_out, sample_in;
    logic               mosi_bit;
    logic [DATA_W-1:0]  rx_byte;
    logic [FRAME_W-1:0] load_val;

    assign req_ready = (state_q == ST_IDLE);
    assign busy      = !req_ready;
    assign accept    = req_valid && req_ready;
    assign half_run  = (state_q == ST_LEAD) || (state_q == ST_LOW) || (state_q == ST_HIGH);
    assign last_bit  = (bit_q == LAST_BIT);
    assign frame_end = (state_q == ST_HIGH) && half_exp && last_bit;
    assign shift_out = (state_q == ST_HIGH) && half_exp && !last_bit;
    assign sample_in = (state_q == ST_LOW) && half_exp;
    assign load_val  = {req_write, req_addr, (req_write ? req_wdata : {DATA_W{1'b0}})};
    assign spi_mosi  = !spi_cs_n && mosi_bit;

    sensor_spi_halfcnt #(
        .HALF_CYC (HALF_CYC)
    ) u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (half_run),
        .expire (half_exp)
    );

    sensor_spi_gap_timer #(
        .TICK_CYC (TICK_CYC),
        .LONG_US  (WR_GAP_US),
        .SHORT_US (RD_GAP_US)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q == ST_GAP),
        .long_sel (!is_read_q),
        .expire   (gap_exp)
    );

    sensor_spi_shifter #(
        .FRAME_W (FRAME_W),
        .DATA_W  (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_val  (load_val),
        .shift_out (shift_out),
        .sample_in (sample_in),
        .miso      (spi_miso),
        .mosi_bit  (mosi_bit),
        .rx_byte   (rx_byte)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_LEAD;
            ST_LEAD: if (half_exp)  state_d = ST_LOW;
            ST_LOW:  if (half_exp)  state_d = ST_HIGH;
            ST_HIGH: if (half_exp)  state_d = last_bit ? ST_GAP : ST_LOW;
            ST_GAP:  if (gap_exp)   state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // Bit position within the frame, advanced on each falling edge after the first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else if (accept) begin
            bit_q <= '0;
        end else if (shift_out) begin
            bit_q <= bit_q + BIT_W'(1);
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spi_cs_n  <= 1'b1;
            spi_sclk  <= 1'b1;
            done      <= 1'b0;
            rdata     <= '0;
            is_read_q <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        spi_cs_n  <= 1'b0;
                        is_read_q <= !req_write;
                    end
                end
                ST_LEAD: begin
                    if (half_exp) spi_sclk <= 1'b0;
                end
                ST_LOW: begin
                    if (half_exp) spi_sclk <= 1'b1;
                end
                ST_HIGH: begin
                    if (frame_end) begin
                        spi_cs_n <= 1'b1;
                        if (is_read_q) begin
                            rdata <= rx_byte;
                            done  <= 1'b1;
                        end
                    end else if (half_exp) begin
                        spi_sclk <= 1'b0;
                    end
                end
                ST_GAP: begin
                    spi_cs_n <= 1'b1;
                    spi_sclk <= 1'b1;
                end
                default: begin
                    spi_cs_n <= 1'b1;
                    spi_sclk <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/sensor_reg_spi_chk.sv
module sensor_reg_spi_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic busy,
    input logic done,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi
);

    assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> spi_sclk);

    assert_mosi_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && spi_sclk && $past(spi_sclk) && !$past(spi_cs_n)) |-> $stable(spi_mosi));

    assert_accept_starts_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !spi_cs_n);

    // R6 and R7: a released chip select always opens a busy gap
    assert_gap_after_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> busy);

    assert_done_at_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_cs_n && !$past(spi_cs_n)));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_cs_n && spi_sclk && !spi_mosi));

endmodule

bind sensor_reg_spi sensor_reg_spi_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .busy      (busy),
    .done      (done),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi)
);

// File: tb/sensor_reg_spi_bench.sv
`timescale 1ns/1ps
module sensor_reg_spi_bench;

    localparam int CLK_FREQ  = 8_000_000;
    localparam int SCLK_FREQ = 2_000_000;
    localparam int WR_US     = 120;
    localparam int RD_US     = 20;
    localparam int H         = CLK_FREQ / (2 * SCLK_FREQ);
    localparam int TICK      = CLK_FREQ / 1_000_000;
    localparam int FRAME_CYC = 33 * H;
    localparam int WR_GAP    = WR_US * TICK;
    localparam int RD_GAP    = RD_US * TICK;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic [6:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [7:0] rdata;
    logic       done;
    logic       busy;
    logic       spi_cs_n;
    logic       spi_sclk;
    logic       spi_mosi;
    logic       spi_miso = 1'b0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // sensor model state
    logic [7:0]  sens_byte = '0;
    logic [15:0] cap = '0;
    int          fall_idx = 0;
    logic        prev_sclk = 1'b1;
    logic        prev_cs = 1'b1;
    logic        prev_mosi = 1'b0;

    always #2 clk = ~clk;

    sensor_reg_spi #(
        .CLK_FREQ  (CLK_FREQ),
        .SCLK_FREQ (SCLK_FREQ),
        .WR_GAP_US (WR_US),
        .RD_GAP_US (RD_US)
    ) u_sensor_reg_spi (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rdata     (rdata),
        .done      (done),
        .busy      (busy),
        .spi_cs_n  (spi_cs_n),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-cycle line model: mode 3 rules, bit capture, sensor answer
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(!(spi_cs_n && !spi_sclk), "R1 clock parked high", spi_sclk, 1);
            if (!spi_cs_n && !prev_cs && spi_sclk && prev_sclk)
                check(spi_mosi == prev_mosi, "R1 mosi steady while clock high", spi_mosi, prev_mosi);
            if (spi_cs_n && prev_cs) begin
                fall_idx = 0;
                cap = '0;
            end
            if (!spi_cs_n && spi_sclk && !prev_sclk)
                cap = {cap[14:0], spi_mosi};
            if (!spi_cs_n && !spi_sclk && prev_sclk) begin
                if (fall_idx >= 8) spi_miso = sens_byte[7 - (fall_idx - 8)];
                else               spi_miso = 1'b0;
                fall_idx++;
            end
            prev_sclk = spi_sclk;
            prev_cs   = spi_cs_n;
            prev_mosi = spi_mosi;
        end
    end

    task automatic frame(input bit wr, input logic [6:0] a, input logic [7:0] wd, input logic [7:0] sens);
        logic [7:0]  old_rdata;
        logic [15:0] exp_bits;
        int          lo;
        bit          early_done;
        sens_byte = sens;
        old_rdata = rdata;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!spi_cs_n, "R4 chip select low after accept", spi_cs_n, 0);
        lo = 0;
        early_done = 0;
        while (!spi_cs_n) begin
            lo++;
            if (done) early_done = 1;
            @(negedge clk);
        end
        check(lo == FRAME_CYC, "R4 chip select low length", lo, FRAME_CYC);
        check(!early_done, "R5 no done inside frame", early_done, 0);
        exp_bits = wr ? {1'b1, a, wd} : {1'b0, a, 8'h00};
        if (wr) check(cap == exp_bits, "R2 write frame bits", cap, exp_bits);
        else    check(cap == exp_bits, "R3 read frame bits", cap, exp_bits);
        if (wr) begin
            check(!done, "R5 no done after write", done, 0);
            check(rdata == old_rdata, "R5 rdata kept on write", rdata, old_rdata);
        end else begin
            check(done, "R5 done on release", done, 1);
            check(rdata == sens, "R5 read byte", rdata, sens);
            @(negedge clk);
            check(!done, "R5 done one cycle", done, 0);
            lo = 1;
        end
    endtask

    // Count the busy cycles from the release of chip select
    task automatic gap(input int exp_cyc, input int already, input string req);
        int  g;
        bit  bad;
        g = already;
        bad = 0;
        while (busy) begin
            g++;
            if (!spi_cs_n || req_ready) bad = 1;
            @(negedge clk);
        end
        check(g == exp_cyc, req, g, exp_cyc);
        check(!bad, "R8 ready low and chip select high in gap", bad, 0);
        check(req_ready, "R8 ready after gap", req_ready, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R9 reset state
        check(spi_cs_n == 1'b1, "R9 cs_n reset", spi_cs_n, 1);
        check(spi_sclk == 1'b1, "R9 sclk reset", spi_sclk, 1);
        check(spi_mosi == 1'b0, "R9 mosi reset", spi_mosi, 0);
        check(!busy && req_ready, "R9 ready reset", req_ready, 1);
        check(!done && rdata == 8'h00, "R9 done and rdata reset", rdata, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        frame(1'b1, 7'h0F, 8'h29, 8'h00); gap(WR_GAP, 0, "R6 write gap");
        frame(1'b0, 7'h02, 8'h00, 8'hA5); gap(RD_GAP, 1, "R7 read gap");
        frame(1'b0, 7'h7F, 8'hFF, 8'h00); gap(RD_GAP, 1, "R7 read gap all-ones address");
        frame(1'b0, 7'h00, 8'h00, 8'hFF); gap(RD_GAP, 1, "R7 read gap zero address");
        frame(1'b1, 7'h7F, 8'hFF, 8'h3C); gap(WR_GAP, 0, "R6 write gap ones");
        frame(1'b1, 7'h00, 8'h00, 8'h3C); gap(WR_GAP, 0, "R6 write gap zeros");

        // R8: request held through a write gap, then served
        frame(1'b1, 7'h20, 8'h5A, 8'h00);
        req_write = 1'b0; req_addr = 7'h2A; req_valid = 1'b1;
        gap(WR_GAP, 0, "R6 write gap with held request");
        frame(1'b0, 7'h2A, 8'h00, 8'h96);
        // R8: request held through a read gap
        req_write = 1'b1; req_addr = 7'h10; req_wdata = 8'hC3; req_valid = 1'b1;
        gap(RD_GAP, 1, "R7 read gap with held request");
        frame(1'b1, 7'h10, 8'hC3, 8'h00); gap(WR_GAP, 0, "R6 final write gap");

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule